// File: doc/BRIEF.md
# Burst-Safe Re-Arbitration Point Scheduler

This block sits on one slave port of a multi-master interconnect and follows the transfer stream of the master that currently owns the port. It watches the transfer type, burst type and ready signals. It pulses a registered "arbitrate now" strobe only in cycles where ownership can move to another master without splitting a burst. The strobe comes with a 2-bit code that gives the reason.

There are four reasons. The first is an idle cycle, or a single transfer. The second is the last beat of a fixed-length burst. The third is a programmable beat boundary inside an undefined-length incrementing burst, which stops such bursts from holding the slave for too long. The fourth is a slot-cycle watchdog: it reloads at every arbitration point, counts down each clock, and once it has run out it forces a handover at the next completed beat. The master-selection policy, address decoding and data steering belong to the surrounding arbiter.

Top module: `arb_point_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `arb_now` is 0 and `arb_cause` is 0.
- R2: A cycle with `hready`=1 and `htrans`=IDLE (2'b00) produces `arb_now`=1 with `arb_cause`=0 in the next cycle.
- R3: An accepted beat (`hready`=1, `htrans` NONSEQ 2'b10 or SEQ 2'b11) with `hburst`=SINGLE (3'b000) produces `arb_now`=1 with `arb_cause`=0 in the next cycle.
- R4: For `hburst` WRAP4/INCR4 (3'b010/3'b011), WRAP8/INCR8 (3'b100/3'b101) and WRAP16/INCR16 (3'b110/3'b111), the strobe rises with `arb_cause`=1 in the cycle after the 4th, 8th or 16th accepted beat, counted from the last accepted NONSEQ. Earlier beats of the burst give no burst-derived strobe.
- R5: `ulbt` selects a slice length for INCR (3'b001) bursts: 1→1, 2→4, 3→8, 4→16, 5→32, 6→64, 7→128 beats. The cycle after every accepted beat whose index is a multiple of the slice length carries `arb_now`=1 with `arb_cause`=2.
- R6: With `ulbt`=0, beats of an INCR burst never raise a strobe by themselves.
- R7: Cycles with `hready`=0, or with `htrans`=BUSY (2'b01), produce no strobe in the next cycle and leave the beat index unchanged. A NONSEQ restarts the index at 1.
- R8: Every strobe cycle loads the slot counter from `slot_limit`. The counter then drops by one per clock and saturates at zero. Once it is zero, the counter stays expired, and each accepted beat without a higher-priority cause produces `arb_now`=1 with `arb_cause`=3. That strobe reloads the counter.
- R9: A `slot_limit` of 0, loaded at an arbitration point, disables the slot cut until the next load.
- R10: When several causes apply in one cycle, the code follows the priority 0 > 1 > 2 > 3. The strobe lasts one cycle per arbitration point, and `arb_cause` reads 0 whenever `arb_now` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htrans | input | 2 | Transfer type of the current owner |
| hburst | input | 3 | Burst type of the current owner |
| hready | input | 1 | Transfer completion on the slave port |
| ulbt | input | 3 | Slice setting for undefined-length bursts of the current owner |
| slot_limit | input | SLOT_W | Slot cycle limit of this slave (0 = off) |
| arb_now | output | 1 | One-cycle re-arbitration strobe |
| arb_cause | output | 2 | Reason for the strobe: 0 idle/single, 1 burst end, 2 slice boundary, 3 slot cut |

## Verification
The bench builds the block with `SLOT_W`=6, `BEAT_W`=8 and the slot timer enabled. With a 6-bit limit, the counter can run out within a few beats. This means slot cuts, and slot cuts that land on the same beat as a burst end, occur often in both the directed and the random streams. `BEAT_W`=8 lets an unlimited INCR burst wrap its index, and lets a 128-beat slice be checked across its boundary.

// File: rtl/arb_sched_pkg.sv
package arb_sched_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_e;

   typedef enum logic [2:0] {
      BU_SINGLE = 3'd0,
      BU_INCR   = 3'd1,
      BU_WRAP4  = 3'd2,
      BU_INCR4  = 3'd3,
      BU_WRAP8  = 3'd4,
      BU_INCR8  = 3'd5,
      BU_WRAP16 = 3'd6,
      BU_INCR16 = 3'd7
   } burst_e;

   typedef enum logic [1:0] {
      CA_IDLE_SINGLE = 2'd0,
      CA_BURST_END   = 2'd1,
      CA_INCR_SLICE  = 2'd2,
      CA_SLOT_CUT    = 2'd3
   } cause_e;

   localparam int unsigned SLICE_BITS = 7;

   // Beat count of a fixed-length burst; 0 for single or undefined length.
   function automatic logic [4:0] fixed_len(input logic [2:0] b);
      case (b)
         3'd2, 3'd3: fixed_len = 5'd4;
         3'd4, 3'd5: fixed_len = 5'd8;
         3'd6, 3'd7: fixed_len = 5'd16;
         default:    fixed_len = 5'd0;
      endcase
   endfunction

   // Low index bits that must be zero at a slice boundary.
   function automatic logic [SLICE_BITS-1:0] slice_mask(input logic [2:0] u);
      case (u)
         3'd2:    slice_mask = 7'h03;
         3'd3:    slice_mask = 7'h07;
         3'd4:    slice_mask = 7'h0f;
         3'd5:    slice_mask = 7'h1f;
         3'd6:    slice_mask = 7'h3f;
         3'd7:    slice_mask = 7'h7f;
         default: slice_mask = 7'h00;
      endcase
   endfunction

endpackage

// File: rtl/arb_beat_track.sv
module arb_beat_track #(
   parameter int unsigned BEAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_i,
   input  logic              first_i,
   output logic [BEAT_W-1:0] idx_o
);

   logic [BEAT_W-1:0] cnt_q;

   assign idx_o = first_i ? BEAT_W'(1) : cnt_q + BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (beat_i) begin
         cnt_q <= idx_o;
      end
   end

   // R7: stalled or busy cycles leave the index untouched
   a_r7_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_i |=> $stable(cnt_q));

   // R7: a first beat always lands on index 1
   a_r7_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_i && first_i) |=> (cnt_q == BEAT_W'(1)));

endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
   parameter int unsigned SLOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [SLOT_W-1:0] limit_i,
   output logic              expired_o
);

   logic [SLOT_W-1:0] left_q;
   logic              armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         armed_q <= 1'b0;
      end else if (load_i) begin
         left_q  <= limit_i;
         armed_q <= (limit_i != '0);
      end else if (left_q != '0) begin
         left_q  <= left_q - SLOT_W'(1);
      end
   end

   assign expired_o = armed_q && (left_q == '0);

   // R9: a zero limit leaves the cut disarmed
   a_r9_zero_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && limit_i == '0) |=> !expired_o);

   // R8: a fresh nonzero load is never already expired
   a_r8_reload_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && limit_i != '0) |=> !expired_o);

   // R8: once expired, stays expired until a reload
   a_r8_sticky_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/arb_point_decide.sv
module arb_point_decide
   import arb_sched_pkg::*;
#(
   parameter int unsigned BEAT_W = 8
) (
   input  logic [1:0]        htrans_i,
   input  logic [2:0]        hburst_i,
   input  logic              hready_i,
   input  logic [2:0]        ulbt_i,
   input  logic [BEAT_W-1:0] idx_i,
   input  logic              slot_exp_i,
   output logic              beat_o,
   output logic              first_o,
   output logic              event_o,
   output logic [1:0]        cause_o
);

   logic              is_idle;
   logic              is_single;
   logic              is_end;
   logic              is_slice;
   logic [4:0]        len;
   logic [SLICE_BITS-1:0] mask;

   assign beat_o  = hready_i && htrans_i[1];
   assign first_o = (htrans_i == TR_NONSEQ);
   assign len     = fixed_len(hburst_i);
   assign mask    = slice_mask(ulbt_i);

   assign is_idle   = hready_i && (htrans_i == TR_IDLE);
   assign is_single = beat_o && (hburst_i == BU_SINGLE);
   assign is_end    = beat_o && (len != 5'd0) && (idx_i == BEAT_W'(len));
   assign is_slice  = beat_o && (hburst_i == BU_INCR) && (ulbt_i != 3'd0)
                      && ((idx_i[SLICE_BITS-1:0] & mask) == '0);

   always_comb begin
      event_o = 1'b1;
      cause_o = CA_IDLE_SINGLE;
      if (is_idle || is_single) begin
         cause_o = CA_IDLE_SINGLE;
      end else if (is_end) begin
         cause_o = CA_BURST_END;
      end else if (is_slice) begin
         cause_o = CA_INCR_SLICE;
      end else if (beat_o && slot_exp_i) begin
         cause_o = CA_SLOT_CUT;
      end else begin
         event_o = 1'b0;
      end
   end

endmodule

// File: rtl/arb_point_sched.sv
module arb_point_sched
   import arb_sched_pkg::*;
#(
   parameter int unsigned SLOT_W  = 8,
   parameter int unsigned BEAT_W  = 8,
   parameter bit          SLOT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        htrans,
   input  logic [2:0]        hburst,
   input  logic              hready,
   input  logic [2:0]        ulbt,
   input  logic [SLOT_W-1:0] slot_limit,
   output logic              arb_now,
   output logic [1:0]        arb_cause
);

   localparam int unsigned MIN_BEAT_W = SLICE_BITS + 1;

   if (BEAT_W < MIN_BEAT_W) begin : g_bad_beat_w
      $error("BEAT_W must cover a 128-beat slice");
   end
   if (SLOT_W < 1 || SLOT_W > 16) begin : g_bad_slot_w
      $error("SLOT_W out of range");
   end

   logic              beat;
   logic              first;
   logic              ev;
   logic [1:0]        cause;
   logic [BEAT_W-1:0] idx;
   logic              slot_exp;

   arb_beat_track #(.BEAT_W(BEAT_W)) beat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_i  (beat),
      .first_i (first),
      .idx_o   (idx)
   );

   if (SLOT_EN) begin : g_slot
      arb_slot_timer #(.SLOT_W(SLOT_W)) slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (ev),
         .limit_i   (slot_limit),
         .expired_o (slot_exp)
      );
   end else begin : g_no_slot
      assign slot_exp = 1'b0;
   end

   arb_point_decide #(.BEAT_W(BEAT_W)) decide_i (
      .htrans_i   (htrans),
      .hburst_i   (hburst),
      .hready_i   (hready),
      .ulbt_i     (ulbt),
      .idx_i      (idx),
      .slot_exp_i (slot_exp),
      .beat_o     (beat),
      .first_o    (first),
      .event_o    (ev),
      .cause_o    (cause)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arb_now   <= 1'b0;
         arb_cause <= 2'd0;
      end else begin
         arb_now   <= ev;
         arb_cause <= ev ? cause : 2'd0;
      end
   end

   // R2: idle with ready is an arbitration point
   a_r2_idle_point: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && htrans == TR_IDLE) |=> (arb_now && arb_cause == 2'd0));

   // R3: accepted single transfer is an arbitration point
   a_r3_single_point: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && htrans[1] && hburst == BU_SINGLE) |=> (arb_now && arb_cause == 2'd0));

   // R7: wait states and busy cycles never hand over
   a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready || htrans == TR_BUSY) |=> !arb_now);

   // R10: the code reads zero while the strobe is low
   a_r10_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_now |-> (arb_cause == 2'd0));

   // R6: unlimited INCR continuation without slot expiry stays quiet
   a_r6_unlimited_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && htrans == TR_SEQ && hburst == BU_INCR && ulbt == 3'd0 && !slot_exp)
      |=> !arb_now);

endmodule

// File: tb/arb_point_sched_tb_top.sv
module arb_point_sched_tb_top;

   localparam int unsigned SLOT_W = 6;
   localparam int unsigned BEAT_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        htrans = 2'b00;
   logic [2:0]        hburst = 3'd0;
   logic              hready = 1'b1;
   logic [2:0]        ulbt = 3'd0;
   logic [SLOT_W-1:0] slot_limit = '0;
   logic              arb_now;
   logic [1:0]        arb_cause;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   logic [BEAT_W-1:0] m_cnt = '0;
   int                m_left = 0;
   bit                m_armed = 1'b0;

   always #4 clk = ~clk;

   arb_point_sched #(.SLOT_W(SLOT_W), .BEAT_W(BEAT_W), .SLOT_EN(1'b1)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .htrans     (htrans),
      .hburst     (hburst),
      .hready     (hready),
      .ulbt       (ulbt),
      .slot_limit (slot_limit),
      .arb_now    (arb_now),
      .arb_cause  (arb_cause)
   );

   function automatic int burst_beats(input logic [2:0] b);
      if (b == 3'd2 || b == 3'd3) return 4;
      if (b == 3'd4 || b == 3'd5) return 8;
      if (b == 3'd6 || b == 3'd7) return 16;
      return 0;
   endfunction

   function automatic int slice_beats(input logic [2:0] u);
      if (u == 3'd0) return 0;
      if (u == 3'd1) return 1;
      return 1 << u;
   endfunction

   function automatic string tag_for(input bit e, input logic [1:0] c, input logic [1:0] t);
      if (!e) return "R6/R7/R9";
      case (c)
         2'd0: return (t == 2'b00) ? "R2" : "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input bit e_now, input logic [1:0] e_cause);
      checks++;
      if (arb_now !== e_now || arb_cause !== e_cause) begin
         errors++;
         $display("FAIL %s: arb_now=%0b cause=%0d expected arb_now=%0b cause=%0d",
                  tag, arb_now, arb_cause, e_now, e_cause);
      end
   endtask

   // Drive one cycle at a falling edge, predict, then check one cycle later.
   task automatic step(input logic [1:0] t, input logic [2:0] b, input bit r,
                       input logic [2:0] u, input int lim, input string hint);
      bit          acc;
      bit          e;
      logic [1:0]  c;
      logic [BEAT_W-1:0] ix;
      int          n;
      int          sl;
      htrans = t; hburst = b; hready = r; ulbt = u; slot_limit = SLOT_W'(lim);
      acc = r && t[1];
      ix  = (t == 2'b10) ? BEAT_W'(1) : m_cnt + BEAT_W'(1);
      n   = burst_beats(b);
      sl  = slice_beats(u);
      e = 1'b1; c = 2'd0;
      if ((r && t == 2'b00) || (acc && b == 3'd0)) c = 2'd0;
      else if (acc && n != 0 && int'(ix) == n) c = 2'd1;
      else if (acc && b == 3'd1 && sl != 0 && (int'(ix) % sl) == 0) c = 2'd2;
      else if (acc && m_armed && m_left == 0) c = 2'd3;
      else e = 1'b0;
      if (acc) m_cnt = ix;
      if (e) begin
         m_left = lim; m_armed = (lim != 0);
      end else if (m_left != 0) begin
         m_left--;
      end
      @(posedge clk);
      @(negedge clk);
      check((hint != "") ? hint : tag_for(e, c, t), e, e ? c : 2'd0);
   endtask

   task automatic burst(input logic [2:0] b, input int beats, input logic [2:0] u, input int lim);
      for (int i = 0; i < beats; i++) begin
         step(i == 0 ? 2'b10 : 2'b11, b, 1'b1, u, lim, "");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int sd;
      logic [1:0] rt;
      logic [2:0] rb;
      logic [2:0] ru;
      int rl;
      sd = $urandom(32'h5eed_1234);
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check("R1", 1'b0, 2'd0);
      end
      rst_n = 1'b1;
      check("R1", 1'b0, 2'd0);

      // R2 idle, R3 single
      step(2'b00, 3'd0, 1'b1, 3'd0, 0, "R2");
      step(2'b10, 3'd0, 1'b1, 3'd0, 0, "R3");
      step(2'b10, 3'd0, 1'b0, 3'd0, 0, "R7");
      step(2'b10, 3'd0, 1'b1, 3'd0, 0, "R3");

      // R4 fixed bursts, with a busy and a wait state in INCR4
      step(2'b10, 3'd3, 1'b1, 3'd0, 0, "R4");
      step(2'b01, 3'd3, 1'b1, 3'd0, 0, "R7");
      step(2'b11, 3'd3, 1'b0, 3'd0, 0, "R7");
      step(2'b11, 3'd3, 1'b1, 3'd0, 0, "R4");
      step(2'b11, 3'd3, 1'b1, 3'd0, 0, "R4");
      step(2'b11, 3'd3, 1'b1, 3'd0, 0, "R4");
      burst(3'd4, 8, 3'd0, 0);
      burst(3'd7, 16, 3'd0, 0);
      // R7: NONSEQ in the middle restarts the count
      burst(3'd5, 3, 3'd0, 0);
      burst(3'd5, 8, 3'd0, 0);

      // R5 slices
      burst(3'd1, 12, 3'd2, 0);
      burst(3'd1, 5, 3'd1, 0);
      burst(3'd1, 20, 3'd4, 0);
      burst(3'd1, 130, 3'd7, 0);
      // R6 unlimited, wraps the index
      burst(3'd1, 300, 3'd0, 0);

      // R8 slot cut on unlimited INCR, then R9 disabled
      step(2'b00, 3'd0, 1'b1, 3'd0, 5, "R8");
      burst(3'd1, 20, 3'd0, 5);
      step(2'b00, 3'd0, 1'b1, 3'd0, 0, "R9");
      burst(3'd1, 40, 3'd0, 0);

      // R10: slot expiry coincides with the last beat of INCR4
      step(2'b00, 3'd0, 1'b1, 3'd0, 3, "R10");
      step(2'b10, 3'd3, 1'b1, 3'd0, 3, "R10");
      step(2'b11, 3'd3, 1'b1, 3'd0, 3, "R10");
      step(2'b11, 3'd3, 1'b1, 3'd0, 3, "R10");
      step(2'b11, 3'd3, 1'b1, 3'd0, 3, "R10");

      // constrained random mix
      rb = 3'd1; ru = 3'd0; rl = 0;
      for (int k = 0; k < 6000; k++) begin
         int p;
         p = $urandom_range(0, 99);
         if (p < 8) rt = 2'b00;
         else if (p < 16) rt = 2'b01;
         else if (p < 36) rt = 2'b10;
         else rt = 2'b11;
         if (rt == 2'b10) begin
            rb = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) rb = 3'd1;
            ru = 3'($urandom_range(0, 7));
         end
         if ($urandom_range(0, 49) == 0) rl = $urandom_range(0, 15);
         step(rt, rb, ($urandom_range(0, 3) != 0), ru, rl, "");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule